// File: doc/BRIEF.md
# Counter and Compare CSR Unit

This unit keeps one 64-bit free-running count and one compare register and serves them through a single-cycle CSR access port. A core presents an address, an operation and an operand. In the same cycle the unit returns the old value of the addressed register, sign-extended to the destination register width. It also raises an illegal-access flag when the access cannot be honoured. At the next clock edge it commits the read-modify-write result. The `XLEN` parameter picks a 32- or 64-bit machine. With 32 bits, extra high-half addresses expose the upper word of the count.

The cycle, time and retired-instruction views, and the writable generic count, are aliases of the same shared count. A timer interrupt becomes pending when the low `XLEN` bits of the count reach the compare value. It stays pending until software writes the compare register.

Top module: `ctr_cmp_csr`

## Requirements
- R1: Decoded addresses are 0xC00, 0xC01 and 0xC02 (read-only cycle, time and retired-instruction views), 0x506 (count), 0x507 (compare), 0xC80, 0xC81 and 0xC82 (read-only high views) and 0x586 (count-high). Any other address with `csr_en` high sets `csr_illegal` in the same cycle, returns zero on `csr_rdata` and changes no state.
- R2: The three views at 0xC00 to 0xC02 and the count at 0x506 all return the low `XLEN` bits of the one shared count. A write, set or clear to any read-only view (low or high) is illegal, returns zero and changes no state.
- R3: With `XLEN`=32, reading 0xC80, 0xC81, 0xC82 or 0x586 returns count bits 63:32.
- R4: With `XLEN`=64, any access to 0xC80, 0xC81, 0xC82 or 0x586 is illegal and leaves the count untouched.
- R5: `csr_op` encodes 0 = read only, 1 = write (new = operand), 2 = set (new = old OR operand), 3 = clear (new = old AND NOT operand). `csr_rdata` always carries the old value.
- R6: Reset clears the count. After reset the count rises by one on every clock edge that carries no count or count-high write.
- R7: A write-type access to 0x506 loads the whole count with the new value sign-extended to 64 bits. This takes priority over the increment.
- R8: A write-type access to 0x586 (`XLEN`=32) sets count bits 63:32 to the new value. Bits 31:0 keep their value and do not increment in that cycle.
- R9: `csr_rdata` is the old `XLEN`-bit value sign-extended to `REGW` bits.
- R10: Compare resets to all ones and `timer_irq` resets low. One edge after the low `XLEN` count bits equal compare, `timer_irq` goes high. It then stays high until compare is written.
- R11: Any legal write-type access to compare (including a set or clear with a zero operand) clears `timer_irq` at the next edge. This takes priority over a match in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_en | input | 1 | Access valid this cycle |
| csr_op | input | 2 | Operation: 0 read, 1 write, 2 set, 3 clear |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | XLEN | Operand for write, set or clear |
| csr_rdata | output | REGW | Old value, sign-extended |
| csr_illegal | output | 1 | Access not honoured |
| timer_irq | output | 1 | Pending timer interrupt |

## Verification
A read-only sweep over all 4096 addresses separates decoded from undecoded addresses. Across the decoded ones it also separates the low-word aliases from the high-word ones. Write, set and clear accesses go to compare, count and count-high, using operands with the top bit set and clear. These tell apart the operation encodings, the sign extension of both the returned value and the loaded count, and whether a high-half write preserves or increments the low word. Writes to each read-only view check that an illegal access changes nothing. A compare placed a few counts ahead, then rewritten, separates the one-edge match latency, the sticky pending state and the clearing write. A second 64-bit instance confirms that high-half addresses trap there.

// File: rtl/ccsr_pkg.sv
package ccsr_pkg;
  localparam int CNT_W  = 64;
  localparam int HALF_W = 32;
  localparam int ADDR_W = 12;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_SET   = 2'd2,
    OP_CLEAR = 2'd3
  } csr_op_e;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_VIEW,
    SEL_VIEWH,
    SEL_CNT,
    SEL_CNTH,
    SEL_CMP
  } csr_sel_e;

  localparam logic [ADDR_W-1:0] A_CYC    = 12'hC00;
  localparam logic [ADDR_W-1:0] A_TIM    = 12'hC01;
  localparam logic [ADDR_W-1:0] A_RET    = 12'hC02;
  localparam logic [ADDR_W-1:0] A_CYCH   = 12'hC80;
  localparam logic [ADDR_W-1:0] A_TIMH   = 12'hC81;
  localparam logic [ADDR_W-1:0] A_RETH   = 12'hC82;
  localparam logic [ADDR_W-1:0] A_CNT    = 12'h506;
  localparam logic [ADDR_W-1:0] A_CNTH   = 12'h586;
  localparam logic [ADDR_W-1:0] A_CMP    = 12'h507;
endpackage

// File: rtl/ccsr_decode.sv
module ccsr_decode
  import ccsr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              en,
  input  csr_op_e           op,
  input  logic [ADDR_W-1:0] addr,
  output csr_sel_e          sel,
  output logic              illegal,
  output logic              wr_cnt,
  output logic              wr_cnt_hi,
  output logic              wr_cmp
);
  localparam bit HAS_HI = (XLEN == HALF_W);

  logic is_wr;
  logic ro;
  logic ok;

  always_comb begin
    sel = SEL_NONE;
    case (addr)
      A_CYC, A_TIM, A_RET:    sel = SEL_VIEW;
      A_CYCH, A_TIMH, A_RETH: sel = HAS_HI ? SEL_VIEWH : SEL_NONE;
      A_CNT:                  sel = SEL_CNT;
      A_CNTH:                 sel = HAS_HI ? SEL_CNTH : SEL_NONE;
      A_CMP:                  sel = SEL_CMP;
      default:                sel = SEL_NONE;
    endcase
  end

  always_comb begin
    is_wr     = (op != OP_READ);
    ro        = (sel == SEL_VIEW) || (sel == SEL_VIEWH);
    illegal   = en && ((sel == SEL_NONE) || (ro && is_wr));
    ok        = en && !illegal;
    wr_cnt    = ok && is_wr && (sel == SEL_CNT);
    wr_cnt_hi = ok && is_wr && (sel == SEL_CNTH);
    wr_cmp    = ok && is_wr && (sel == SEL_CMP);
  end
endmodule

// File: rtl/ccsr_counter.sv
module ccsr_counter
  import ccsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_full,
  input  logic              load_hi,
  input  logic [CNT_W-1:0]  full_val,
  input  logic [HALF_W-1:0] hi_val,
  output logic [CNT_W-1:0]  count
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    if (load_full)    cnt_d = full_val;
    else if (load_hi) cnt_d = {hi_val, cnt_q[HALF_W-1:0]};
    else              cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/ccsr_timer.sv
module ccsr_timer #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_cmp,
  input  logic [XLEN-1:0] cmp_new,
  input  logic [XLEN-1:0] cnt_low,
  output logic [XLEN-1:0] cmp,
  output logic            irq
);
  logic [XLEN-1:0] cmp_q;
  logic            irq_q;
  logic            irq_d;
  logic            cmp_ce;

  always_comb begin
    cmp_ce = wr_cmp;
    if (wr_cmp)                 irq_d = 1'b0;
    else if (cnt_low == cmp_q)  irq_d = 1'b1;
    else                        irq_d = irq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmp_q <= '1;
    else if (cmp_ce) cmp_q <= cmp_new;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign cmp = cmp_q;
  assign irq = irq_q;
endmodule

// File: rtl/ctr_cmp_csr.sv
module ctr_cmp_csr
  import ccsr_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int REGW = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_en,
  input  logic [1:0]        csr_op,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic [XLEN-1:0]   csr_wdata,
  output logic [REGW-1:0]   csr_rdata,
  output logic              csr_illegal,
  output logic              timer_irq
);
  csr_op_e          op_e;
  csr_sel_e         sel;
  logic             illegal;
  logic             wr_cnt;
  logic             wr_cnt_hi;
  logic             wr_cmp;
  logic [CNT_W-1:0] count_q;
  logic [XLEN-1:0]  cmp_q;
  logic [XLEN-1:0]  old_val;
  logic [XLEN-1:0]  rd_val;
  logic [XLEN-1:0]  new_val;
  logic [CNT_W-1:0] full_val;

  assign op_e = csr_op_e'(csr_op);

  ccsr_decode #(.XLEN(XLEN)) u_dec (
    .en        (csr_en),
    .op        (op_e),
    .addr      (csr_addr),
    .sel       (sel),
    .illegal   (illegal),
    .wr_cnt    (wr_cnt),
    .wr_cnt_hi (wr_cnt_hi),
    .wr_cmp    (wr_cmp)
  );

  always_comb begin
    case (sel)
      SEL_VIEW, SEL_CNT:   old_val = count_q[XLEN-1:0];
      SEL_VIEWH, SEL_CNTH: old_val = XLEN'(count_q[CNT_W-1:HALF_W]);
      SEL_CMP:             old_val = cmp_q;
      default:             old_val = '0;
    endcase
  end

  always_comb begin
    case (op_e)
      OP_WRITE: new_val = csr_wdata;
      OP_SET:   new_val = old_val | csr_wdata;
      OP_CLEAR: new_val = old_val & ~csr_wdata;
      default:  new_val = old_val;
    endcase
  end

  assign rd_val = illegal ? '0 : old_val;

  generate
    if (REGW > XLEN) begin : g_rd_sext
      assign csr_rdata = {{(REGW-XLEN){rd_val[XLEN-1]}}, rd_val};
    end else begin : g_rd_flat
      assign csr_rdata = rd_val;
    end
    if (CNT_W > XLEN) begin : g_ld_sext
      assign full_val = {{(CNT_W-XLEN){new_val[XLEN-1]}}, new_val};
    end else begin : g_ld_flat
      assign full_val = new_val;
    end
  endgenerate

  ccsr_counter u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_full (wr_cnt),
    .load_hi   (wr_cnt_hi),
    .full_val  (full_val),
    .hi_val    (new_val[HALF_W-1:0]),
    .count     (count_q)
  );

  ccsr_timer #(.XLEN(XLEN)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_cmp  (wr_cmp),
    .cmp_new (new_val),
    .cnt_low (count_q[XLEN-1:0]),
    .cmp     (cmp_q),
    .irq     (timer_irq)
  );

  assign csr_illegal = illegal;
endmodule

// File: rtl/ccsr_chk.sv
module ccsr_chk
  import ccsr_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int REGW = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              csr_en,
  input logic [ADDR_W-1:0] csr_addr,
  input logic [REGW-1:0]   csr_rdata,
  input logic              csr_illegal,
  input logic              timer_irq,
  input logic              wr_cnt,
  input logic              wr_cnt_hi,
  input logic              wr_cmp,
  input logic [CNT_W-1:0]  count_q
);
  // R1
  idle_no_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_en |-> !csr_illegal);

  // R1
  illegal_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csr_illegal |-> (csr_rdata == '0));

  // R6
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_cnt && !wr_cnt_hi) |=> (count_q == $past(count_q) + CNT_W'(1)));

  // R10
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (timer_irq && !wr_cmp) |=> timer_irq);

  // R11
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmp |=> !timer_irq);

  generate
    if (XLEN == HALF_W) begin : g_hi
      // R8
      hi_keeps_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt_hi |=> (count_q[HALF_W-1:0] == $past(count_q[HALF_W-1:0])));
    end else begin : g_nohi
      // R4
      hi_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_en && (csr_addr == A_CYCH || csr_addr == A_TIMH ||
                    csr_addr == A_RETH || csr_addr == A_CNTH)) |-> csr_illegal);
    end
    if (REGW > XLEN) begin : g_sx
      // R9
      rdata_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&csr_rdata[REGW-1:XLEN-1]) || !(|csr_rdata[REGW-1:XLEN-1]));
    end
  endgenerate
endmodule

bind ctr_cmp_csr ccsr_chk #(.XLEN(XLEN), .REGW(REGW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .csr_en      (csr_en),
  .csr_addr    (csr_addr),
  .csr_rdata   (csr_rdata),
  .csr_illegal (csr_illegal),
  .timer_irq   (timer_irq),
  .wr_cnt      (wr_cnt),
  .wr_cnt_hi   (wr_cnt_hi),
  .wr_cmp      (wr_cmp),
  .count_q     (count_q)
);

// File: tb/sim_ctr_cmp_csr.sv
module sim_ctr_cmp_csr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [1:0]  op = 2'd0;
  logic [11:0] addr = 12'h0;
  logic [31:0] wd = 32'h0;
  logic [63:0] rdata;
  logic        ill;
  logic        irq;

  logic        en1 = 1'b0;
  logic [1:0]  op1 = 2'd0;
  logic [11:0] addr1 = 12'h0;
  logic [63:0] wd1 = 64'h0;
  logic [63:0] rdata1;
  logic        ill1;
  logic        irq1;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  ctr_cmp_csr #(.XLEN(32), .REGW(64)) u0 (
    .clk(clk), .rst_n(rst_n), .csr_en(en), .csr_op(op), .csr_addr(addr),
    .csr_wdata(wd), .csr_rdata(rdata), .csr_illegal(ill), .timer_irq(irq)
  );

  ctr_cmp_csr #(.XLEN(64), .REGW(64)) u1 (
    .clk(clk), .rst_n(rst_n), .csr_en(en1), .csr_op(op1), .csr_addr(addr1),
    .csr_wdata(wd1), .csr_rdata(rdata1), .csr_illegal(ill1), .timer_irq(irq1)
  );

  // Behavioural expectation for the 32-bit instance
  logic [63:0] m_cnt;
  logic [31:0] m_cmp;
  logic        m_irq;
  logic [63:0] m1_cnt;

  function automatic bit is_view(input logic [11:0] a);
    return a == 12'hC00 || a == 12'hC01 || a == 12'hC02;
  endfunction
  function automatic bit is_viewh(input logic [11:0] a);
    return a == 12'hC80 || a == 12'hC81 || a == 12'hC82;
  endfunction
  function automatic bit known32(input logic [11:0] a);
    return is_view(a) || is_viewh(a) || a == 12'h506 || a == 12'h586 || a == 12'h507;
  endfunction
  function automatic bit ill32(input logic e, input logic [1:0] o, input logic [11:0] a);
    return e && (!known32(a) || ((is_view(a) || is_viewh(a)) && o != 2'd0));
  endfunction
  function automatic logic [31:0] old32(input logic [11:0] a);
    if (is_view(a) || a == 12'h506) return m_cnt[31:0];
    if (is_viewh(a) || a == 12'h586) return m_cnt[63:32];
    if (a == 12'h507) return m_cmp;
    return 32'h0;
  endfunction
  function automatic logic [31:0] newv(input logic [1:0] o, input logic [31:0] old, input logic [31:0] d);
    case (o)
      2'd1: return d;
      2'd2: return old | d;
      2'd3: return old & ~d;
      default: return old;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= 64'h0; m_cmp <= 32'hFFFF_FFFF; m_irq <= 1'b0; m1_cnt <= 64'h0;
    end else begin
      logic w;
      logic [31:0] nv;
      w  = en && !ill32(en, op, addr) && op != 2'd0;
      nv = newv(op, old32(addr), wd);
      if (w && addr == 12'h506)      m_cnt <= {{32{nv[31]}}, nv};
      else if (w && addr == 12'h586) m_cnt <= {nv, m_cnt[31:0]};
      else                           m_cnt <= m_cnt + 64'd1;
      if (w && addr == 12'h507) begin m_cmp <= nv; m_irq <= 1'b0; end
      else if (m_cnt[31:0] == m_cmp) m_irq <= 1'b1;
      if (en1 && op1 == 2'd1 && addr1 == 12'h506) m1_cnt <= wd1;
      else                                        m1_cnt <= m1_cnt + 64'd1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic acc(input logic [1:0] o, input logic [11:0] a, input logic [31:0] d, input string req);
    logic        e_ill;
    logic [31:0] e_old;
    logic [63:0] e_rd;
    @(negedge clk);
    en = 1'b1; op = o; addr = a; wd = d;
    #5;
    e_ill = ill32(1'b1, o, a);
    e_old = e_ill ? 32'h0 : old32(a);
    e_rd  = {{32{e_old[31]}}, e_old};
    check(rdata == e_rd && ill == e_ill && irq == m_irq, req,
          {rdata[61:0], ill, irq}, {e_rd[61:0], e_ill, m_irq});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      en = 1'b0; op = 2'd0; addr = 12'h0; wd = 32'h0;
      #5;
      check(irq == m_irq && !ill, "R10 idle irq", {63'h0, irq}, {63'h0, m_irq});
    end
  endtask

  task automatic acc1(input logic [1:0] o, input logic [11:0] a, input logic [63:0] d, input string req);
    logic e_ill;
    @(negedge clk);
    en1 = 1'b1; op1 = o; addr1 = a; wd1 = d;
    #5;
    e_ill = !(a == 12'hC00 || a == 12'hC01 || a == 12'hC02 ||
              a == 12'h506 || a == 12'h507) || (a[11:8] == 4'hC && o != 2'd0);
    check(ill1 == e_ill, req, {63'h0, ill1}, {63'h0, e_ill});
    if (!e_ill && a != 12'h507) check(rdata1 == m1_cnt, req, rdata1, m1_cnt);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    en = 1'b1; addr = 12'h506; op = 2'd0;
    repeat (3) @(negedge clk);
    #5;
    // R6 R10 reset state
    check(rdata == 64'h0 && !irq, "R6 reset count", rdata, 64'h0);
    rst_n = 1'b1;

    // R1 R2 R3 R9: read sweep across every address
    for (int a = 0; a < 4096; a++) acc(2'd0, a[11:0], 32'h0, "R1 sweep");

    // R5 R9 compare operations
    acc(2'd1, 12'h507, 32'hF0F0_1234, "R5 cmp write");
    acc(2'd2, 12'h507, 32'h0000_0F00, "R5 cmp set");
    acc(2'd3, 12'h507, 32'hF000_0034, "R5 cmp clear");
    acc(2'd0, 12'h507, 32'h0, "R9 cmp read sext");

    // R7 count write, sign extended
    acc(2'd1, 12'h506, 32'h8000_0005, "R7 count load");
    acc(2'd0, 12'h586, 32'h0, "R7 high word all ones");
    acc(2'd0, 12'hC00, 32'h0, "R2 cycle view after load");
    acc(2'd1, 12'h506, 32'h0000_0100, "R7 count load pos");
    acc(2'd0, 12'hC81, 32'h0, "R3 time high zero");

    // R8 count-high write keeps the low word
    acc(2'd1, 12'h586, 32'h1234_5678, "R8 high write");
    acc(2'd0, 12'h506, 32'h0, "R8 low kept");
    acc(2'd0, 12'hC82, 32'h0, "R8 high read back");
    acc(2'd2, 12'h586, 32'h8000_0000, "R8 high set");
    acc(2'd3, 12'h586, 32'h0000_0078, "R8 high clear");
    acc(2'd0, 12'hC80, 32'h0, "R3 cycle high");

    // R2 writes to read-only views are illegal and have no effect
    acc(2'd1, 12'hC00, 32'hDEAD_BEEF, "R2 ro write");
    acc(2'd2, 12'hC01, 32'hFFFF_FFFF, "R2 ro set");
    acc(2'd3, 12'hC82, 32'hFFFF_FFFF, "R2 ro clear high");
    acc(2'd1, 12'h123, 32'hFFFF_FFFF, "R1 unknown write");
    acc(2'd0, 12'h506, 32'h0, "R2 count unchanged");
    acc(2'd0, 12'h507, 32'h0, "R2 cmp unchanged");

    // R10 R11 timer interrupt
    acc(2'd1, 12'h507, m_cnt[31:0] + 32'd6, "R10 arm cmp");
    idle(10);
    acc(2'd0, 12'hC01, 32'h0, "R10 irq held");
    acc(2'd2, 12'h507, 32'h0, "R11 cmp set zero clears");
    idle(2);
    acc(2'd1, 12'h507, m_cnt[31:0] + 32'd1, "R11 arm again");
    acc(2'd1, 12'h507, m_cnt[31:0], "R11 write wins over match");
    idle(3);
    en = 1'b0;

    // R4 R7: 64-bit instance
    acc1(2'd0, 12'hC00, 64'h0, "R2 x64 view");
    acc1(2'd0, 12'hC80, 64'h0, "R4 x64 cycleh");
    acc1(2'd0, 12'hC81, 64'h0, "R4 x64 timeh");
    acc1(2'd0, 12'hC82, 64'h0, "R4 x64 instreth");
    acc1(2'd1, 12'h586, 64'hFFFF_FFFF_FFFF_FFFF, "R4 x64 counth write");
    acc1(2'd0, 12'h506, 64'h0, "R4 x64 count untouched");
    acc1(2'd1, 12'h506, 64'h8765_4321_0FED_CBA9, "R7 x64 load");
    acc1(2'd0, 12'h506, 64'h0, "R7 x64 readback");
    @(negedge clk);
    en1 = 1'b0;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule